// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit supervisory timer. The system clock drives a prescaler that offers eight divide ratios. When the timer is enabled, an up-counter advances once per selected prescaler period. When the counter wraps from 0xFF to 0x00, one of two things happens, depending on a mode bit. In watchdog mode, the block drives an overflow pulse of fixed length and can also raise a reset request. In interval mode, it latches a flag, and that flag drives an interrupt line until software clears it.

Software reaches three byte-wide registers through a small bus port. Writes are accepted only as 16-bit words, and the upper byte must carry a key. The key selects the target register; any other key leaves the write without effect. Reads are accepted only as bytes, and the read addresses differ from the write addresses. Every access, read or write, takes exactly three cycles. The port signals the third cycle with `bus_ready`.

Top module: `guard_timer`

## Requirements
- R1: After reset the control register reads 0x18, the counter reads 0x00, the reset-status register reads 0x1F, and `wd_over`, `rst_req` and `tick_irq` are low.
- R2: Every access completes in three cycles. `bus_ready` is high for one cycle only, the third cycle of `bus_sel`, and a write takes effect at the end of that cycle.
- R3: Only word writes (`bus_word`=1) act. At address 0, upper byte 0xA5 writes the control register and 0x5A writes the counter. At address 2, upper byte 0x5A writes the reset-status register. Byte writes and any other key change nothing, and a word read returns 0x00.
- R4: Byte reads return the control register at address 1'b0 (address 0), the counter at address 1, the reset-status register at address 3, and 0x00 at address 2. `bus_rdata` is 0x00 whenever `bus_ready` is low.
- R5: Control register layout: bit 7 interval flag, bit 6 mode (1 = watchdog, 0 = interval), bit 5 enable, bits 4:3 read as 1, bits 2:0 clock select. Reset-status layout: bit 7 watchdog flag, bit 6 reset enable, bit 5 reads 0, bits 4:0 read as 1.
- R6: Clock-select codes 0 to 7 divide by 2, 64, 128, 256, 512, 1024, 4096 and 8192. The first increment after enable comes exactly one ratio of cycles after the enabling write commits.
- R7: While enable is 0 the counter holds its value. A control write with bit 5 = 0 clears the counter to 0x00.
- R8: In interval mode a wrap sets the interval flag. `tick_irq` is high from the cycle after the wrap until the flag is cleared, and the counter keeps counting.
- R9: Both flags can only be cleared. Writing 0 to bit 7 clears the flag, writing 1 leaves it unchanged, and a wrap in the same cycle as a clearing write leaves the flag set.
- R10: In watchdog mode a wrap sets the watchdog flag and drives `wd_over` high for PULSE_LEN cycles, starting the cycle after the wrap. The interval flag and `tick_irq` stay low.
- R11: `rst_req` is high over the same window as `wd_over` if the reset enable was 1 at the wrap, and stays low otherwise.
- R12: A counter write loads the written byte, whether the timer is enabled or not, and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write word: key in the upper byte, value in the lower byte |
| bus_ready | output | 1 | Access completion, third cycle |
| bus_rdata | output | 8 | Read byte, valid while `bus_ready` is high |
| wd_over | output | 1 | Watchdog overflow pulse |
| rst_req | output | 1 | Internal reset request |
| tick_irq | output | 1 | Interval interrupt request |

## Verification
A prescaler or counter that is off by even one state shows up as a wrap one or more cycles early or late. The bench therefore samples `tick_irq` and `wd_over` on the exact cycle before and the exact cycle of the expected wrap, for every clock-select code. A flag or mode register holding a wrong value appears on the interrupt or pulse lines within one cycle of the next wrap, and on the byte read of the status registers within three cycles. A key decode error is visible on the first read-back after the rejected or accepted write.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

   localparam int SEL_W = 3;
   localparam int SEL_N = 1 << SEL_W;

   // register addresses on the bus port
   localparam logic [1:0] WA_MAIN = 2'd0;
   localparam logic [1:0] WA_RST  = 2'd2;
   localparam logic [1:0] RA_CTL  = 2'd0;
   localparam logic [1:0] RA_CNT  = 2'd1;
   localparam logic [1:0] RA_RST  = 2'd3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_DONE = 2'd2
   } bus_ph_e;

   // log2 of the divide ratio for each clock-select code
   function automatic int tap_shift(input int code);
      case (code)
         0: return 1;
         1: return 6;
         2: return 7;
         3: return 8;
         4: return 9;
         5: return 10;
         6: return 12;
         default: return 13;
      endcase
   endfunction

endpackage

// File: rtl/gt_prescale.sv
module gt_prescale
   import guard_timer_pkg::*;
#(
   parameter int PRE_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [PRE_W-1:0] pre_q;
   logic [SEL_N-1:0] tap;

   if (PRE_W < tap_shift(SEL_N - 1)) begin : g_bad_width
      $error("gt_prescale: PRE_W too small for the largest ratio");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < SEL_N; g++) begin : g_tap
      localparam int SH = tap_shift(g);
      assign tap[g] = &pre_q[SH-1:0];
   end

   assign tick = run & tap[sel];

endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = tick & (&cnt_q) & ~load & ~clr;
   assign cnt  = cnt_q;

endmodule

// File: rtl/gt_bus_port.sv
module gt_bus_port
   import guard_timer_pkg::*;
#(
   parameter logic [7:0] KEY_CTL = 8'hA5,
   parameter logic [7:0] KEY_CNT = 8'h5A,
   parameter logic [7:0] KEY_RST = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        we,
   input  logic        word,
   input  logic [1:0]  addr,
   input  logic [15:0] wdata,
   output logic        ready,
   output logic        wr_ctl,
   output logic        wr_cnt,
   output logic        wr_rst,
   output logic [7:0]  wbyte,
   output logic        rd_ok,
   output logic [1:0]  rd_addr
);

   bus_ph_e     ph_q;
   logic        we_q, word_q;
   logic [1:0]  addr_q;
   logic [15:0] data_q;
   logic        wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         we_q   <= 1'b0;
         word_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: if (sel) begin
               ph_q   <= PH_WAIT;
               we_q   <= we;
               word_q <= word;
               addr_q <= addr;
               data_q <= wdata;
            end
            PH_WAIT: ph_q <= PH_DONE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ready   = (ph_q == PH_DONE);
   assign wr_ok   = ready & we_q & word_q;
   assign wr_ctl  = wr_ok & (addr_q == WA_MAIN) & (data_q[15:8] == KEY_CTL);
   assign wr_cnt  = wr_ok & (addr_q == WA_MAIN) & (data_q[15:8] == KEY_CNT);
   assign wr_rst  = wr_ok & (addr_q == WA_RST)  & (data_q[15:8] == KEY_RST);
   assign wbyte   = data_q[7:0];
   assign rd_ok   = ~we_q & ~word_q;
   assign rd_addr = addr_q;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import guard_timer_pkg::*;
#(
   parameter int         CNT_W     = 8,
   parameter int         PRE_W     = 13,
   parameter int         PULSE_LEN = 8,
   parameter logic [7:0] KEY_CTL   = 8'hA5,
   parameter logic [7:0] KEY_CNT   = 8'h5A,
   parameter logic [7:0] KEY_RST   = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic        bus_word,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic        bus_ready,
   output logic [7:0]  bus_rdata,
   output logic        wd_over,
   output logic        rst_req,
   output logic        tick_irq
);

   localparam int PW = $clog2(PULSE_LEN + 1);

   if (CNT_W != 8) begin : g_bad_cnt
      $error("guard_timer: counter must be one byte wide");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("guard_timer: PULSE_LEN must be at least 1");
   end
   if (KEY_CTL == KEY_CNT) begin : g_bad_key
      $error("guard_timer: control and counter keys must differ");
   end

   logic             bp_ready, wr_ctl, wr_cnt, wr_rst, rd_ok;
   logic [7:0]       wbyte;
   logic [1:0]       rd_addr;
   logic             iflag_q, mode_q, csr_en_q;
   logic [SEL_W-1:0] cks_q;
   logic             wflag_q, rst_en_q, req_q;
   logic [PW-1:0]    pulse_q;
   logic             tick, wrap, wd_wrap, iv_wrap;
   logic [CNT_W-1:0] cnt_val;
   logic [7:0]       ctl_view, rst_view, rd_mux;

   gt_bus_port #(.KEY_CTL(KEY_CTL), .KEY_CNT(KEY_CNT), .KEY_RST(KEY_RST)) u_port (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .word(bus_word),
      .addr(bus_addr), .wdata(bus_wdata), .ready(bp_ready), .wr_ctl(wr_ctl),
      .wr_cnt(wr_cnt), .wr_rst(wr_rst), .wbyte(wbyte), .rd_ok(rd_ok),
      .rd_addr(rd_addr)
   );

   gt_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(csr_en_q), .sel(cks_q), .tick(tick)
   );

   gt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .clr(wr_ctl & ~wbyte[5]), .load(wr_cnt), .load_val(wbyte),
      .cnt(cnt_val), .wrap(wrap)
   );

   assign wd_wrap = wrap & mode_q;
   assign iv_wrap = wrap & ~mode_q;

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iflag_q  <= 1'b0;
         mode_q   <= 1'b0;
         csr_en_q <= 1'b0;
         cks_q    <= '0;
      end else begin
         if (iv_wrap)                 iflag_q <= 1'b1;
         else if (wr_ctl & ~wbyte[7]) iflag_q <= 1'b0;
         if (wr_ctl) begin
            mode_q   <= wbyte[6];
            csr_en_q <= wbyte[5];
            cks_q    <= wbyte[SEL_W-1:0];
         end
      end
   end

   // reset-status register and overflow pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wflag_q  <= 1'b0;
         rst_en_q <= 1'b0;
         req_q    <= 1'b0;
         pulse_q  <= '0;
      end else begin
         if (wd_wrap)                 wflag_q <= 1'b1;
         else if (wr_rst & ~wbyte[7]) wflag_q <= 1'b0;
         if (wr_rst) rst_en_q <= wbyte[6];
         if (wd_wrap) begin
            pulse_q <= PW'(PULSE_LEN);
            req_q   <= rst_en_q;
         end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
         end
      end
   end

   assign ctl_view = {iflag_q, mode_q, csr_en_q, 2'b11, cks_q};
   assign rst_view = {wflag_q, rst_en_q, 1'b0, 5'h1F};

   always_comb begin
      rd_mux = 8'h00;
      if (bp_ready && rd_ok) begin
         case (rd_addr)
            RA_CTL:  rd_mux = ctl_view;
            RA_CNT:  rd_mux = cnt_val;
            RA_RST:  rd_mux = rst_view;
            default: rd_mux = 8'h00;
         endcase
      end
   end

   assign bus_ready = bp_ready;
   assign bus_rdata = rd_mux;
   assign wd_over   = (pulse_q != '0);
   assign rst_req   = req_q & (pulse_q != '0);
   assign tick_irq  = iflag_q;

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_ready,
   input logic [7:0]       bus_rdata,
   input logic             wd_over,
   input logic             rst_req,
   input logic             tick_irq,
   input logic             en_q,
   input logic [CNT_W-1:0] cnt_q
);

   p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   p_ready_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> $past(bus_sel, 2));

   p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |-> (bus_rdata == 8'h00));

   p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !bus_ready) |=> $stable(cnt_q));

   p_irq_from_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_irq) |-> (cnt_q == '0));

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_irq && !bus_ready) |=> tick_irq);

   p_pulse_from_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_over) |-> (cnt_q == '0));

   p_req_in_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> wd_over);

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_ready(bus_ready),
   .bus_rdata(bus_rdata), .wd_over(wd_over), .rst_req(rst_req),
   .tick_irq(tick_irq), .en_q(csr_en_q), .cnt_q(cnt_val)
);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;

   localparam int PULSE = 8;
   localparam int RATIO [8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_ready, wd_over, rst_req, tick_irq;
   logic [7:0]  bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   guard_timer #(.PULSE_LEN(PULSE)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .wd_over(wd_over),
      .rst_req(rst_req), .tick_irq(tick_irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // starts and returns on a falling edge; R2 timing checked on every access
   task automatic bus_op(input logic we, input logic word, input logic [1:0] a,
                         input logic [15:0] d, output logic [7:0] q);
      int waits = 0;
      bus_sel = 1'b1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = d;
      do begin
         @(negedge clk);
         waits++;
      end while (!bus_ready && waits < 10);
      q = bus_rdata;
      check("R2 ready cycle", waits, 2);
      @(negedge clk);
      bus_sel = 1'b0;
      check("R2 ready single", bus_ready, 1'b0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      logic [7:0] q;
      bus_op(1'b1, 1'b1, a, d, q);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] q);
      bus_op(1'b0, 1'b0, a, 16'h0000, q);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 wd_over", wd_over, 1'b0);
      check("R1 rst_req", rst_req, 1'b0);
      check("R1 tick_irq", tick_irq, 1'b0);
      rd(2'd0, q); check("R1 ctl", q, 8'h18);
      rd(2'd1, q); check("R1 cnt", q, 8'h00);
      rd(2'd3, q); check("R1 rst", q, 8'h1F);
      rd(2'd2, q); check("R4 hole", q, 8'h00);

      // R3 key and size rules
      wr(2'd0, 16'h3361);
      rd(2'd0, q); check("R3 bad key", q, 8'h18);
      bus_op(1'b1, 1'b0, 2'd0, 16'hA561, q);
      rd(2'd0, q); check("R3 byte write", q, 8'h18);
      bus_op(1'b0, 1'b1, 2'd0, 16'h0000, q);
      check("R3 word read", q, 8'h00);

      // R12 load while disabled, R7 hold and clear
      wr(2'd0, 16'h5A37);
      rd(2'd1, q); check("R12 load", q, 8'h37);
      repeat (50) @(negedge clk);
      rd(2'd1, q); check("R7 hold", q, 8'h37);
      wr(2'd0, 16'hA500);
      rd(2'd1, q); check("R7 clear", q, 8'h00);

      // R5 layout, R9 writing 1 to a clear flag
      wr(2'd0, 16'hA5C6);
      rd(2'd0, q); check("R5 ctl layout", q, 8'h5E);
      wr(2'd0, 16'hA500);

      // R6 ratio table walk in interval mode
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, 16'hA500);
         wr(2'd0, 16'h5AFF);
         wr(2'd0, {8'hA5, 8'h20 | 8'(i)});
         repeat (RATIO[i] - 1) @(negedge clk);
         check($sformatf("R6 early code %0d", i), tick_irq, 1'b0);
         @(negedge clk);
         check($sformatf("R6 wrap code %0d", i), tick_irq, 1'b1);
         check("R8 no pulse in interval", wd_over, 1'b0);
      end

      // R8 counter keeps running after the wrap
      wr(2'd0, 16'hA500);
      wr(2'd0, 16'h5AFE);
      wr(2'd0, 16'hA520);
      repeat (3) @(negedge clk);
      check("R8 before wrap", tick_irq, 1'b0);
      @(negedge clk);
      check("R8 irq", tick_irq, 1'b1);
      repeat (6) @(negedge clk);
      rd(2'd1, q); check("R8 running", q, 8'h04);
      check("R8 irq held", tick_irq, 1'b1);
      wr(2'd0, 16'hA5A0);
      check("R9 write 1 keeps", tick_irq, 1'b1);
      wr(2'd0, 16'hA520);
      check("R9 clear irq", tick_irq, 1'b0);
      rd(2'd0, q); check("R9 ctl after clear", q, 8'h38);

      // R10 watchdog without reset enable
      wr(2'd0, 16'hA500);
      wr(2'd0, 16'h5AFE);
      wr(2'd0, 16'hA560);
      repeat (3) @(negedge clk);
      check("R10 before wrap", wd_over, 1'b0);
      @(negedge clk);
      check("R10 pulse start", wd_over, 1'b1);
      check("R11 no request", rst_req, 1'b0);
      check("R10 no irq", tick_irq, 1'b0);
      repeat (PULSE - 1) @(negedge clk);
      check("R10 pulse last", wd_over, 1'b1);
      @(negedge clk);
      check("R10 pulse end", wd_over, 1'b0);
      rd(2'd3, q); check("R10 rst flag", q, 8'h9F);
      rd(2'd0, q); check("R10 ctl flag clear", q, 8'h78);

      // R9 on the reset-status flag, R3 bad key there
      wr(2'd2, 16'h5AC0);
      rd(2'd3, q); check("R9 rst write 1 keeps", q, 8'hDF);
      wr(2'd2, 16'h1100);
      rd(2'd3, q); check("R3 rst bad key", q, 8'hDF);
      wr(2'd2, 16'h5A40);
      rd(2'd3, q); check("R9 rst clear", q, 8'h5F);

      // R11 watchdog with reset enable
      wr(2'd0, 16'hA500);
      wr(2'd0, 16'h5AFE);
      wr(2'd0, 16'hA560);
      repeat (4) @(negedge clk);
      check("R11 request", rst_req, 1'b1);
      check("R11 pulse", wd_over, 1'b1);
      repeat (PULSE) @(negedge clk);
      check("R11 request end", rst_req, 1'b0);
      wr(2'd0, 16'hA500);
      rd(2'd3, q); check("R11 rst reg", q, 8'hDF);

      summary();
   end

endmodule